// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Port

This block is an 8-bit synchronous serial port with three pins: serial data out, serial data in and a serial clock. Software sees a small register bus with three locations: a control register that enables the port and selects master or slave operation, a status register that carries a transfer-complete flag and a write-collision flag, and one data register that holds the byte to send and, once a transfer ends, the byte that was received. In master mode the port makes its own serial clock from the system clock through a fixed divider. In slave mode it follows a clock driven from outside, which it brings into the system clock domain before use.

Bit order and clock divider are fixed when the block is built, through the `LSB_FIRST` and `DIV_SEL` parameters. The serial clock idles high. Outgoing data changes on the falling edge and incoming data is sampled on the rising edge. The register bus has no back-pressure: every read or write finishes in the cycle it is presented, and read data is combinational from the address. There is no streaming interface, so no valid/ready rules apply. The output-enable pins let a surrounding pin multiplexer hand the pins to the port only while it is enabled.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, `sck_o` is high and both output enables are low.
- R2: In master mode with the port enabled, a data-register write (address 2) while idle starts a transfer. The serial clock period is `8 << DIV_SEL` system clocks and is high for the first half. The first falling edge comes half a period after the write edge, and exactly 8 periods follow before the clock rests high again.
- R3: `sdo_o` changes only on a falling serial-clock edge. The j-th falling edge presents data bit j when `LSB_FIRST`=1, or bit 7-j when it is 0.
- R4: `sdi_i` is sampled on each rising edge and shifted in the same order, so that after a transfer the data register reads the received byte with the first received bit in the first sent position.
- R5: The transfer-complete flag (status bit 7) sets on the clock edge of the 8th rising serial edge and not earlier. The transfer is then over.
- R6: A data-register write during a transfer sets the write-collision flag (status bit 6). It leaves the byte being shifted unchanged, and the transfer goes on with its original data.
- R7: Both flags clear when a status read that saw a flag set is followed by a data-register read or write. A data-register access with no such prior status read leaves the flags set.
- R8: A data-register write while the port is disabled loads the register but starts no transfer: the clock stays high and no flag sets.
- R9: In slave mode the port shifts on edges of `sck_i`: data out on falling edges, data in on rising edges. The transfer-complete flag sets after the 8th rising edge.
- R10: `sdo_oe` is high exactly when the port is enabled. `sck_oe` is high exactly when it is enabled and in master mode.
- R11: Control bit 0 is enable and bit 1 is master select. They read back as written, and all other control and status bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the divider source |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sdi_i | input | 1 | Serial data in |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pin |
| sck_o | output | 1 | Serial clock out (master mode) |
| sck_oe | output | 1 | Output enable for the clock pin |

## Verification
The bench builds the port with `DIV_SEL`=0, the fastest divider of 8 system clocks per bit. This keeps a full byte at 64 cycles, so several master transfers, a collision and a full slave transfer fit in a short run. It also selects `LSB_FIRST`=1, the non-default order, so a bit-order mistake in either shift direction shows up against the reference model. That model predicts the clock level and the data-out bit on every cycle. A status read placed one cycle before the final edge tests the exact timing of the completion flag.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MST_BIT  = 1;
  localparam int unsigned STAT_DONE_BIT = 7;
  localparam int unsigned STAT_COLL_BIT = 6;

  function automatic int unsigned div_of(input int unsigned sel);
    return 32'd8 << sel;
  endfunction
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_idle_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/sio_sck_edges.sv
module sio_sck_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic master,
  input  logic tick,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sck_q,
  output logic fall,
  output logic rise,
  output logic sdi_eff
);
  logic [2:0] sck_sync;
  logic [1:0] sdi_sync;
  logic       m_on, s_on;

  assign m_on = en && master;
  assign s_on = en && !master;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= 1'b1;
      sck_sync <= 3'b111;
      sdi_sync <= '0;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_i};
      sdi_sync <= {sdi_sync[0], sdi_i};
      if (!m_on)     sck_q <= 1'b1;
      else if (tick) sck_q <= ~sck_q;
    end
  end

  always_comb begin
    if (m_on) begin
      fall = tick && sck_q;
      rise = tick && !sck_q;
    end else begin
      fall = s_on && sck_sync[2] && !sck_sync[1];
      rise = s_on && !sck_sync[2] && sck_sync[1];
    end
  end

  assign sdi_eff = master ? sdi_i : sdi_sync[1];

  p_no_double_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && rise));
  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !m_on |=> sck_q);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int unsigned W         = 8,
  parameter bit          LSB_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         slave,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         start,
  input  logic         fall,
  input  logic         rise,
  input  logic         sdi,
  output logic [W-1:0] data,
  output logic         sdo,
  output logic         busy,
  output logic         xfer_end
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     shreg;
  logic [W-1:0]     shifted;
  logic             out_bit;
  logic [CNT_W-1:0] bitcnt;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign out_bit = shreg[0];
      assign shifted = {sdi, shreg[W-1:1]};
    end else begin : g_msb
      assign out_bit = shreg[W-1];
      assign shifted = {shreg[W-2:0], sdi};
    end
  endgenerate

  assign xfer_end = en && busy && rise && (bitcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bitcnt <= '0;
      sdo    <= 1'b1;
    end else if (!en) begin
      busy   <= 1'b0;
      bitcnt <= '0;
    end else begin
      if (start || (fall && slave && !busy)) begin
        busy   <= 1'b1;
        bitcnt <= '0;
      end else if (rise && busy) begin
        if (bitcnt == LAST) begin
          busy   <= 1'b0;
          bitcnt <= '0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
      if (fall && (busy || slave)) sdo <= out_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (load)                   shreg <= ld_data;
    else if (en && rise && busy) shreg <= shifted;
  end

  assign data = shreg;

  p_bitcnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= LAST);
  p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !busy);
  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));
  p_busy_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise) |=> $stable(shreg));
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              w_en_bit,
  input  logic              w_mst_bit,
  input  logic              busy,
  input  logic              xfer_end,
  output logic              en,
  output logic              master,
  output logic              done,
  output logic              coll,
  output logic              start,
  output logic              load
);
  logic armed;
  logic data_acc, data_wr, stat_rd;

  assign data_wr  = wr && (addr == A_DATA);
  assign data_acc = (wr || rd) && (addr == A_DATA);
  assign stat_rd  = rd && (addr == A_STAT);
  assign load     = data_wr && !busy;
  assign start    = load && en && master;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      master <= 1'b0;
      done   <= 1'b0;
      coll   <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (wr && addr == A_CTRL) begin
        en     <= w_en_bit;
        master <= w_mst_bit;
      end
      if (data_acc)                    armed <= 1'b0;
      else if (stat_rd && (done || coll)) armed <= 1'b1;
      if (xfer_end)                    done <= 1'b1;
      else if (data_acc && armed)      done <= 1'b0;
      if (data_wr && busy)             coll <= 1'b1;
      else if (data_acc && armed)      coll <= 1'b0;
    end
  end

  p_coll_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> coll);
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done);
  p_clear_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && armed && !xfer_end) |=> !done);
  p_keep_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !armed && done) |=> done);
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          LSB_FIRST = 1'b0,
  parameter int unsigned DIV_SEL   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sdi_i,
  input  logic              sck_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic              sck_o,
  output logic              sck_oe
);
  localparam int unsigned HALF = div_of(DIV_SEL) / 2;

  logic en, master, done, coll, start, load;
  logic busy, xfer_end, tick, fall, rise, sdi_eff, sck_q;
  logic [DATA_W-1:0] data;

  sio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .w_en_bit(reg_wdata[CTRL_EN_BIT]), .w_mst_bit(reg_wdata[CTRL_MST_BIT]),
    .busy(busy), .xfer_end(xfer_end), .en(en), .master(master),
    .done(done), .coll(coll), .start(start), .load(load)
  );

  sio_clkgen #(.HALF(HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(en && master && busy), .tick(tick)
  );

  sio_sck_edges u_edges (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .tick(tick),
    .sck_i(sck_i), .sdi_i(sdi_i), .sck_q(sck_q), .fall(fall), .rise(rise),
    .sdi_eff(sdi_eff)
  );

  sio_shifter #(.W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .slave(!master), .load(load),
    .ld_data(reg_wdata), .start(start), .fall(fall), .rise(rise),
    .sdi(sdi_eff), .data(data), .sdo(sdo_o), .busy(busy), .xfer_end(xfer_end)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_EN_BIT]  = en;
        reg_rdata[CTRL_MST_BIT] = master;
      end
      A_STAT: begin
        reg_rdata[STAT_DONE_BIT] = done;
        reg_rdata[STAT_COLL_BIT] = coll;
      end
      A_DATA:  reg_rdata = data;
      default: reg_rdata = '0;
    endcase
  end

  assign sck_o  = sck_q;
  assign sdo_oe = en;
  assign sck_oe = en && master;

  p_idle_sck_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !busy) |-> sck_o);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_no_run_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

// File: tb/sim_sio_port.sv
module sim_sio_port;
  localparam int W       = 8;
  localparam int DIV_SEL = 0;
  localparam bit LSB     = 1'b1;
  localparam int DIV     = 8 << DIV_SEL;
  localparam int HALF    = DIV / 2;
  localparam int XFER    = 16 * HALF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sdi, sdi_m = 1'b1, sdi_s = 1'b1, sck_s = 1'b1;
  logic sdo_o, sdo_oe, sck_o, sck_oe;
  bit   in_slave = 1'b0;
  bit   wd_hit = 1'b0;

  assign sdi = in_slave ? sdi_s : sdi_m;

  sio_port #(.DATA_W(W), .LSB_FIRST(LSB), .DIV_SEL(DIV_SEL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .sdi_i(sdi), .sck_i(sck_s),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sck_o(sck_o), .sck_oe(sck_oe)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic ord_bit(input logic [7:0] b, input int j);
    return LSB ? b[j] : b[7-j];
  endfunction

  // behavioural reference model
  bit m_en = 0, m_mst = 0, m_busy = 0, m_was = 0;
  int m_k = 0, m_t = 0;
  logic [7:0] m_tx = '0, m_rx = '0;
  logic exp_sck;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mst = 0; m_busy = 0; m_k = 0;
    end else begin
      m_was = m_busy;
      if (m_busy) begin
        m_k++;
        if (m_k == XFER) m_busy = 0;
      end
      if (wr && addr == 2'd2 && m_en && m_mst && !m_was) begin
        m_busy = 1; m_k = 0; m_tx = wdata;
      end
      if (wr && addr == 2'd0) begin
        m_en = wdata[0]; m_mst = wdata[1];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      m_t = m_busy ? m_k / HALF : 0;
      exp_sck = (m_t % 2 == 0);
      chk(sck_o === exp_sck, "R2 serial clock level", sck_o, exp_sck);
      if (m_busy && m_t >= 1)
        chk(sdo_o === ord_bit(m_tx, (m_t - 1) / 2), "R3 data out bit",
            sdo_o, ord_bit(m_tx, (m_t - 1) / 2));
      sdi_m = (m_busy && m_t >= 1) ? ord_bit(m_rx, (m_t - 1) / 2) : 1'b1;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1'b1;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    report();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, d); chk(d == 8'h00, "R1 control after reset", d, 0);
    reg_read(2'd1, d); chk(d == 8'h00, "R1 status after reset", d, 0);
    chk(sck_o === 1'b1 && sdo_oe === 1'b0 && sck_oe === 1'b0, "R1 pins after reset",
        {sck_o, sdo_oe, sck_oe}, 3'b100);

    // R11 control bits
    reg_write(2'd0, 8'hFC); reg_read(2'd0, d);
    chk(d == 8'h00, "R11 unused control bits", d, 0);

    // R8 write while disabled
    reg_write(2'd0, 8'h02);
    reg_write(2'd2, 8'h3C);
    repeat (XFER + 8) @(negedge clk);
    reg_read(2'd1, d); chk(d == 8'h00, "R8 no flag when disabled", d, 0);
    reg_read(2'd2, d); chk(d == 8'h3C, "R8 register loaded", d, 8'h3C);
    chk(sdo_oe === 1'b0 && sck_oe === 1'b0, "R10 enables off", {sdo_oe, sck_oe}, 0);

    reg_write(2'd0, 8'h03); reg_read(2'd0, d);
    chk(d == 8'h03, "R11 control readback", d, 8'h03);
    chk(sdo_oe === 1'b1 && sck_oe === 1'b1, "R10 master enables", {sdo_oe, sck_oe}, 3);

    // transfer 1 with exact completion timing
    m_rx = 8'h5E;
    reg_write(2'd2, 8'hB4);
    while (!(m_busy && m_k == XFER - 2)) @(negedge clk);
    reg_read(2'd1, d); chk(d == 8'h00, "R5 flag not early", d, 0);
    reg_read(2'd1, d); chk(d == 8'h80, "R5 flag on last edge", d, 8'h80);
    reg_read(2'd2, d); chk(d == 8'h5E, "R4 received byte", d, 8'h5E);
    reg_read(2'd1, d); chk(d == 8'h00, "R7 flags cleared", d, 0);

    // transfer 2 with collision
    m_rx = 8'hC3;
    reg_write(2'd2, 8'h0F);
    repeat (20) @(negedge clk);
    reg_write(2'd2, 8'h99);
    wait_idle();
    repeat (2) @(negedge clk);
    reg_read(2'd2, d); chk(d == 8'hC3, "R4 received despite collision R6", d, 8'hC3);
    reg_read(2'd1, d); chk(d == 8'hC0, "R6 collision and R7 flags kept", d, 8'hC0);
    reg_read(2'd2, d);
    reg_read(2'd1, d); chk(d == 8'h00, "R7 flags cleared after sequence", d, 0);

    // further patterns
    for (int i = 0; i < 2; i++) begin
      logic [7:0] tx;
      tx = (i == 0) ? 8'h00 : 8'h81;
      m_rx = (i == 0) ? 8'hFF : 8'h7E;
      reg_write(2'd2, tx);
      wait_idle();
      reg_read(2'd1, d); chk(d == 8'h80, "R5 flag pattern", d, 8'h80);
      reg_read(2'd2, d); chk(d == m_rx, "R4 received pattern", d, m_rx);
    end

    // slave mode
    reg_write(2'd0, 8'h01);
    in_slave = 1'b1;
    chk(sdo_oe === 1'b1 && sck_oe === 1'b0, "R10 slave enables", {sdo_oe, sck_oe}, 2);
    reg_write(2'd2, 8'hA5);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); sck_s = 1'b0;
      repeat (6) @(negedge clk);
      chk(sdo_o === ord_bit(8'hA5, j), "R9 slave data out", sdo_o, ord_bit(8'hA5, j));
      sdi_s = ord_bit(8'h3A, j); sck_s = 1'b1;
      repeat (6) @(negedge clk);
    end
    reg_read(2'd1, d); chk(d == 8'h80, "R9 slave completion", d, 8'h80);
    reg_read(2'd2, d); chk(d == 8'h3A, "R9 slave received", d, 8'h3A);

    report();
    $finish;
  end
endmodule